// File: doc/BRIEF.md
# Fracturable Dual Multiplexer Logic Element

This block is a programmable logic element with eight inputs and two outputs. It holds two 4-to-1 multiplexer halves. The four data pins are common to both halves, and each half has its own pair of select pins. Each half can invert any of its data inputs, chosen per input by configuration bits. Each half then drives an output that is either taken straight from the multiplexer or passed through its own flip-flop.

With constants on the data pins and the function inputs on the selects, the element realises two independent small functions. It can also realise one wider function that spreads across both halves through the shared data pins. A split-mode bit turns each half into a 2-to-1 selector that looks only at the low select bit. The configuration is shifted in one bit per clock through a serial chain, and the oldest bit appears at the chain output so that several elements can be daisy-chained.

Top module: `dual_mux_le`

## Requirements
- R1: With the split-mode bit at 0, out_a combinationally equals data_in[sel_a] XOR inv_a[sel_a], taking sel_a as an unsigned index. out_b follows the same rule with sel_b and inv_b.
- R2: With the split-mode bit at 1, the upper select bit of each half is forced to 0. Each output then depends only on data_in[0] and data_in[1] through the low select bit, and sel_x[1] has no effect.
- R3: The halves are independent. out_a depends only on data_in, sel_a, inv_a and bypass_a, and out_b depends only on data_in, sel_b, inv_b and bypass_b.
- R4: When a half's bypass bit is 1, its output is the combinational multiplexer value. When the bit is 0, its output is that half's register.
- R5: Both registers share clk and ce. On a rising edge with ce high, each register captures its half's multiplexer value. With ce low, each register holds its value.
- R6: A synchronous rst clears both registers and every configuration bit. rst has priority over ce and cfg_en. After reset, both outputs read 0.
- R7: While cfg_en is high, each rising edge shifts cfg_din into the chain, and cfg_dout shows the oldest bit. After 11 shifts, the bits load in entry order: inv_a[0], inv_a[1], inv_a[2], inv_a[3], bypass_a, inv_b[0] to inv_b[3], bypass_b, and last the split-mode bit. While cfg_en is low, the configuration holds and cfg_din is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and configuration chain |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable shared by both output registers |
| cfg_en | input | 1 | Shift enable of the configuration chain |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output (oldest bit) |
| data_in | input | 4 | Shared data inputs |
| sel_a | input | 2 | Select inputs of half A |
| sel_b | input | 2 | Select inputs of half B |
| out_a | output | 1 | Output of half A |
| out_b | output | 1 | Output of half B |

## Verification
The bench builds the element with its default of four shared data inputs. This gives eight inputs in total, so every configuration can be swept exhaustively over all 256 combinations of data and selects. That sweep is run for hand-picked configurations (wide and split modes, mixed bypass, alternating inversions) and for several random ones. The bench also checks the shift order of the chain through cfg_dout, register hold with ce low, and clearing by reset while the bypass path is selected.

// File: rtl/dmle_pkg.sv
package dmle_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } le_mode_e;

  // Bits per half in the chain: one inversion bit per data input plus bypass.
  function automatic int half_cfg_bits(input int ndata);
    return ndata + 1;
  endfunction
endpackage

// File: rtl/dmle_cfg_chain.sv
module dmle_cfg_chain #(
  parameter int CFG_BITS = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                ser_in,
  output logic [CFG_BITS-1:0] cfg_o,
  output logic                ser_out
);
  logic [CFG_BITS-1:0] chain_q;

  // Newest bit enters at the top, so the first bit shifted lands at bit 0.
  always_ff @(posedge clk) begin
    if (rst)           chain_q <= '0;
    else if (shift_en) chain_q <= {ser_in, chain_q[CFG_BITS-1:1]};
  end

  assign cfg_o   = chain_q;
  assign ser_out = chain_q[0];

  a_r6_chain_reset: assert property (@(posedge clk) rst |=> chain_q == '0);
  a_r7_chain_shift: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (chain_q[CFG_BITS-1] == $past(ser_in)) &&
                 (chain_q[CFG_BITS-2:0] == $past(chain_q[CFG_BITS-1:1])));
  a_r7_chain_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/dmle_mux_half.sv
module dmle_mux_half
  import dmle_pkg::*;
#(
  parameter int NDATA = 4,
  localparam int SELW = $clog2(NDATA)
) (
  input  logic [NDATA-1:0] data_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic [NDATA-1:0] inv_i,
  input  le_mode_e         mode_i,
  output logic             y_o
);
  // In split mode only the low select bit survives.
  function automatic logic [SELW-1:0] narrow_sel(input logic [SELW-1:0] s,
                                                 input le_mode_e m);
    logic [SELW-1:0] r;
    r = s;
    if (m == MODE_SPLIT) r = {{(SELW-1){1'b0}}, s[0]};
    return r;
  endfunction

  function automatic logic pick(input logic [NDATA-1:0] d,
                                input logic [NDATA-1:0] inv,
                                input logic [SELW-1:0]  s);
    logic [NDATA-1:0] cond;
    cond = d ^ inv;
    return cond[s];
  endfunction

  logic [SELW-1:0] eff_sel;
  assign eff_sel = narrow_sel(sel_i, mode_i);
  assign y_o     = pick(data_i, inv_i, eff_sel);
endmodule

// File: rtl/dmle_out_reg.sv
module dmle_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic d_i,
  input  logic bypass_i,
  output logic y_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (ce) q <= d_i;
  end

  assign y_o = bypass_i ? d_i : q;

  a_r6_reg_reset: assert property (@(posedge clk) rst |=> q == 1'b0);
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    ce |=> q == $past(d_i));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));
  a_r4_registered_path: assert property (@(posedge clk) disable iff (rst)
    !bypass_i |-> y_o == q);
endmodule

// File: rtl/dual_mux_le.sv
module dual_mux_le
  import dmle_pkg::*;
#(
  parameter int NDATA = 4,
  localparam int SELW     = $clog2(NDATA),
  localparam int NHALF    = 2,
  localparam int HBITS    = NDATA + 1,
  localparam int CFG_BITS = NHALF * HBITS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic [NDATA-1:0] data_in,
  input  logic [SELW-1:0]  sel_a,
  input  logic [SELW-1:0]  sel_b,
  output logic             out_a,
  output logic             out_b
);
  logic [CFG_BITS-1:0] cfg_w;
  le_mode_e            mode_w;
  logic [SELW-1:0]     sel_h   [NHALF];
  logic [NDATA-1:0]    inv_h   [NHALF];
  logic                byp_h   [NHALF];
  logic                comb_h  [NHALF];
  logic                out_h   [NHALF];

  dmle_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .ser_in(cfg_din),
    .cfg_o(cfg_w), .ser_out(cfg_dout)
  );

  assign mode_w   = le_mode_e'(cfg_w[CFG_BITS-1]);
  assign sel_h[0] = sel_a;
  assign sel_h[1] = sel_b;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign inv_h[h] = cfg_w[h*HBITS +: NDATA];
    assign byp_h[h] = cfg_w[h*HBITS + NDATA];

    dmle_mux_half #(.NDATA(NDATA)) u_mux (
      .data_i(data_in), .sel_i(sel_h[h]), .inv_i(inv_h[h]),
      .mode_i(mode_w), .y_o(comb_h[h])
    );

    dmle_out_reg u_reg (
      .clk(clk), .rst(rst), .ce(ce), .d_i(comb_h[h]),
      .bypass_i(byp_h[h]), .y_o(out_h[h])
    );
  end

  assign out_a = out_h[0];
  assign out_b = out_h[1];

  a_r1_wide_pick: assert property (@(posedge clk) disable iff (rst)
    (mode_w == MODE_WIDE) |-> comb_h[0] == (data_in[sel_a] ^ cfg_w[sel_a]));
  a_r2_split_pick: assert property (@(posedge clk) disable iff (rst)
    (mode_w == MODE_SPLIT) |->
      comb_h[1] == (sel_b[0] ? (data_in[1] ^ cfg_w[HBITS+1])
                             : (data_in[0] ^ cfg_w[HBITS])));
  a_r4_bypass_a: assert property (@(posedge clk) disable iff (rst)
    cfg_w[NDATA] |-> out_a == comb_h[0]);
endmodule

// File: tb/dual_mux_le_tb_top.sv
`timescale 1ns/1ps
module dual_mux_le_tb_top;
  logic clk = 1'b0;
  logic rst, ce, cfg_en, cfg_din, cfg_dout, out_a, out_b;
  logic [3:0] data_in;
  logic [1:0] sel_a, sel_b;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit [3:0] m_inv [2];
  bit       m_byp [2];
  bit       m_split;
  bit       m_reg [2];

  always #5 clk = ~clk;

  dual_mux_le dut_i (
    .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .data_in(data_in), .sel_a(sel_a), .sel_b(sel_b),
    .out_a(out_a), .out_b(out_b)
  );

  function automatic bit ref_fn(bit [3:0] d, int s, bit [3:0] inv, bit split);
    int idx;
    idx = split ? (s % 2) : s;
    return d[idx] != inv[idx];
  endfunction

  function automatic bit ref_out(int h);
    int s;
    bit c;
    s = (h == 0) ? int'(sel_a) : int'(sel_b);
    c = ref_fn(data_in, s, m_inv[h], m_split);
    return m_byp[h] ? c : m_reg[h];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Inputs are already applied; advance one clock and compare at the negedge.
  task automatic step(bit do_check, string tag);
    @(posedge clk);
    #1;
    if (rst) begin
      m_reg[0] = 0; m_reg[1] = 0;
      m_inv[0] = 0; m_inv[1] = 0; m_byp[0] = 0; m_byp[1] = 0; m_split = 0;
    end else if (ce) begin
      m_reg[0] = ref_fn(data_in, int'(sel_a), m_inv[0], m_split);
      m_reg[1] = ref_fn(data_in, int'(sel_b), m_inv[1], m_split);
    end
    @(negedge clk);
    if (do_check) begin
      check($sformatf("%s half A", tag), out_a, ref_out(0));
      check($sformatf("%s half B", tag), out_b, ref_out(1));
    end
  endtask

  task automatic load_cfg(bit [3:0] ia, bit ba, bit [3:0] ib, bit bb, bit sp);
    bit bits [$];
    for (int i = 0; i < 4; i++) bits.push_back(ia[i]);
    bits.push_back(ba);
    for (int i = 0; i < 4; i++) bits.push_back(ib[i]);
    bits.push_back(bb);
    bits.push_back(sp);
    ce = 0;
    cfg_en = 1;
    foreach (bits[k]) begin
      cfg_din = bits[k];
      step(0, "load");
    end
    cfg_en = 0;
    m_inv[0] = ia; m_byp[0] = ba; m_inv[1] = ib; m_byp[1] = bb; m_split = sp;
    check("R7 cfg_dout oldest bit", cfg_dout, ia[0]);
  endtask

  task automatic sweep(string tag);
    ce = 1;
    for (int v = 0; v < 256; v++) begin
      data_in = v[3:0]; sel_a = v[5:4]; sel_b = v[7:6];
      cfg_din = v[0] ^ v[3];   // toggles with cfg_en low: R7 hold
      step(1, tag);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; ce = 0; cfg_en = 0; cfg_din = 0; data_in = 0; sel_a = 0; sel_b = 0;
    @(negedge clk);
    step(0, "reset");
    step(1, "R6 reset state");
    check("R6 cfg cleared", cfg_dout, 1'b0);
    rst = 0;

    // R1 wide mode, both combinational, no inversion; R3 distinct selects
    load_cfg(4'b0000, 1, 4'b0000, 1, 0);
    sweep("R1 R3 R4 wide comb");
    // R1 wide with inversions, A registered, B combinational
    load_cfg(4'b1010, 0, 4'b0110, 1, 0);
    sweep("R1 R4 R5 wide mixed");
    // R2 split mode, sel[1] must be ignored
    load_cfg(4'b0101, 1, 4'b1001, 0, 1);
    sweep("R2 R3 split");
    for (int r = 0; r < 4; r++) begin
      bit [10:0] c;
      c = 11'($urandom);
      load_cfg(c[3:0], c[4], c[8:5], c[9], c[10]);
      sweep($sformatf("R1 R2 R3 R4 random cfg %0d", r));
    end

    // R5 hold with ce low, both registered
    load_cfg(4'b0011, 0, 4'b1100, 0, 0);
    ce = 1; data_in = 4'b1111; sel_a = 2'd1; sel_b = 2'd3;
    step(1, "R5 capture");
    ce = 0;
    for (int k = 0; k < 20; k++) begin
      data_in = 4'(k); sel_a = 2'(k); sel_b = 2'(k + 1);
      step(1, "R5 hold with ce low");
    end

    // R6 reset while bypass selected and ce high: outputs and config clear
    load_cfg(4'b1111, 1, 4'b1111, 1, 0);
    ce = 1; data_in = 4'b0000;
    step(1, "R4 pre-reset comb");
    rst = 1;
    step(1, "R6 reset clears");
    check("R6 out_a after reset", out_a, 1'b0);
    check("R6 out_b after reset", out_b, 1'b0);
    rst = 0;
    step(1, "R6 after release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule